// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block puts a small shared word memory behind several requesters and gives them an atomic read-modify-write primitive built from a reserving load and a conditional store. A reserving load returns the addressed word and records, for that requester only, a reservation on that address. A later conditional store from the same requester to the same address writes the memory only if the reservation is still intact. It then reports success or failure so that the requester can retry from the reserving load. Plain stores, and conditional stores that succeed, break the matching reservations of every other requester.

Each requester has its own valid/ready request channel carrying an operation code, a word address and write data. Each requester also has its own response channel, which answers every accepted request exactly one cycle after the handshake. One memory access is served per cycle, and a fixed-priority selector favours the lowest requester index. A conditional store that is already known to fail never needs the memory. It is accepted in the cycle it is presented, whatever the arbitration, and it is answered with a failure.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no response is valid, every memory word reads zero and no requester holds a reservation, so a conditional store issued before any reserving load fails.
- R2: The operation code is 00 for load, 01 for store, 10 for reserving load and 11 for conditional store. Every accepted request produces exactly one response on that requester's channel, one cycle after the handshake. Loads and reserving loads return the word the memory held at the handshake.
- R3: A plain store writes its data to the addressed word. Its response carries zero data, and every response other than a successful conditional store has the ok flag low.
- R4: A reserving load sets the issuing requester's single reservation to the loaded address, replacing any earlier reservation of that requester.
- R5: A conditional store succeeds only when its requester holds a reservation on exactly the store's address. On success it writes the memory and returns ok high.
- R6: A failed conditional store leaves the memory unchanged and leaves every other requester's reservation untouched.
- R7: A conditional store always removes its own requester's reservation, whether it succeeds or fails.
- R8: A plain store, including a store of zero used as a lock release, or a successful conditional store by one requester removes every other requester's reservation on that address. The writer's own reservation is kept after a plain store.
- R9: Among the requests that need the memory, only the lowest-indexed valid one is made ready in a cycle. Ready is never raised without valid.
- R10: A conditional store whose requester holds no matching reservation is made ready in the cycle it is presented, even while a lower-indexed requester owns the memory, and it is answered with ok low.
- R11: When two conditional stores to one reserved address are presented together, the lower-indexed one is served first and succeeds. The other is held, then fails in the following cycle and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request present, one bit per requester |
| req_op | input | 2*NREQ | Operation code per requester, requester i at bits 2i+1:2i |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Store data per requester |
| req_ready | output | NREQ | Request accepted this cycle |
| rsp_valid | output | NREQ | Response present, one cycle after acceptance |
| rsp_data | output | DW*NREQ | Read data per requester, zero for stores |
| rsp_ok | output | NREQ | High for a successful conditional store |

## Verification
A broken reservation entry cannot be seen directly. It shows up at the ports either as a conditional store whose response has the wrong ok flag, or as a wrong value in a later load of that word. It also shows up as a ready pulse in the wrong cycle, because a doomed conditional store skips arbitration. The ready and response comparisons against a behavioural model on every cycle therefore expose a wrong reservation within two cycles of the conditional store that consults it. A wrong memory word appears in the response of the next load of that address.

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [2*NREQ-1:0]  req_op,
  input  logic [AW*NREQ-1:0] req_addr,
  input  logic [DW*NREQ-1:0] req_wdata,
  output logic [NREQ-1:0]    req_ready,
  output logic [NREQ-1:0]    rsp_valid,
  output logic [DW*NREQ-1:0] rsp_data,
  output logic [NREQ-1:0]    rsp_ok
);
  localparam int DEPTH = 1 << AW;
  localparam int IW    = (NREQ > 1) ? $clog2(NREQ) : 1;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LR = 2'd2, OP_SC = 2'd3;

  logic [DW-1:0]   mem [DEPTH];
  logic [NREQ-1:0] resv_v;
  logic [AW-1:0]   resv_a [NREQ];

  logic [NREQ-1:0] doomed, need, grant;
  logic            sel_v;
  logic [IW-1:0]   sel;
  logic [1:0]      g_op;
  logic [AW-1:0]   g_addr;
  logic [DW-1:0]   g_wdata;
  logic            wr_en;

  for (genvar i = 0; i < NREQ; i++) begin : g_doom
    assign doomed[i] = req_valid[i] && req_op[2*i +: 2] == OP_SC &&
                       !(resv_v[i] && resv_a[i] == req_addr[AW*i +: AW]);
  end

  assign need = req_valid & ~doomed;

  always_comb begin
    sel_v = 1'b0;
    sel   = '0;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (need[i]) begin
        sel_v = 1'b1;
        sel   = IW'(i);
      end
    end
  end

  assign grant     = sel_v ? (NREQ'(1) << sel) : '0;
  assign req_ready = doomed | grant;
  assign g_op      = req_op[2*sel +: 2];
  assign g_addr    = req_addr[AW*sel +: AW];
  assign g_wdata   = req_wdata[DW*sel +: DW];
  assign wr_en     = sel_v && (g_op == OP_ST || g_op == OP_SC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[g_addr] <= g_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_v <= '0;
      for (int i = 0; i < NREQ; i++) resv_a[i] <= '0;
    end else begin
      for (int i = 0; i < NREQ; i++) begin
        if (doomed[i]) begin
          resv_v[i] <= 1'b0;
        end else if (grant[i]) begin
          if (g_op == OP_LR) begin
            resv_v[i] <= 1'b1;
            resv_a[i] <= g_addr;
          end else if (g_op == OP_SC) begin
            resv_v[i] <= 1'b0;
          end
        end else if (wr_en && resv_a[i] == g_addr) begin
          resv_v[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar i = 0; i < NREQ; i++) begin : g_rsp
    logic [1:0] op_i;
    assign op_i = req_op[2*i +: 2];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rsp_valid[i]          <= 1'b0;
        rsp_ok[i]             <= 1'b0;
        rsp_data[DW*i +: DW]  <= '0;
      end else begin
        rsp_valid[i] <= req_valid[i] && req_ready[i];
        rsp_ok[i]    <= grant[i] && op_i == OP_SC;
        rsp_data[DW*i +: DW] <= (grant[i] && (op_i == OP_LD || op_i == OP_LR)) ?
                                mem[req_addr[AW*i +: AW]] : '0;
      end
    end
  end
endmodule

module lrsc_monitor_chk #(
  parameter int NREQ = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NREQ-1:0]   req_valid,
  input logic [2*NREQ-1:0] req_op,
  input logic [NREQ-1:0]   req_ready,
  input logic [NREQ-1:0]   rsp_valid,
  input logic [NREQ-1:0]   rsp_ok,
  input logic [NREQ-1:0]   resv_v
);
  for (genvar i = 0; i < NREQ; i++) begin : g_chk
    a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i]) |=> rsp_valid[i]);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid[i] && req_ready[i]) |=> !rsp_valid[i]);
    a_r3_ok_only_for_sc: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i] && req_op[2*i +: 2] != 2'd3) |=> !rsp_ok[i]);
    a_r5_unreserved_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i] && !resv_v[i]) |=> !rsp_ok[i]);
    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[i] |-> req_valid[i]);
  end

  a_r11_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_ok));
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .resv_v(resv_v)
);

// File: tb/tb_lrsc_monitor.sv
`timescale 1ns/1ps
module tb_lrsc_monitor;
  localparam int N = 4, AW = 4, DW = 32, DEPTH = 16;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic            vld [N];
  logic [1:0]      op  [N];
  logic [AW-1:0]   ad  [N];
  logic [DW-1:0]   wd  [N];

  logic [N-1:0]    req_valid;
  logic [2*N-1:0]  req_op;
  logic [AW*N-1:0] req_addr;
  logic [DW*N-1:0] req_wdata;
  logic [N-1:0]    req_ready, rsp_valid, rsp_ok;
  logic [DW*N-1:0] rsp_data;

  always_comb
    for (int i = 0; i < N; i++) begin
      req_valid[i]         = vld[i];
      req_op[2*i +: 2]     = op[i];
      req_addr[AW*i +: AW] = ad[i];
      req_wdata[DW*i +: DW] = wd[i];
    end

  lrsc_monitor #(.NREQ(N), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ok(rsp_ok));

  int checks = 0, fails = 0;
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_rv  [N];
  logic [AW-1:0] m_ra  [N];
  logic [N-1:0]  last_rdy;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < N; i++) begin vld[i] = 0; op[i] = 0; ad[i] = 0; wd[i] = 0; end
  endtask

  task automatic put(int i, logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] d);
    vld[i] = 1; op[i] = o; ad[i] = a; wd[i] = d;
  endtask

  // one clock: inputs already driven after a falling edge
  task automatic cyc(string tag);
    bit dm [N];
    int g;
    logic [N-1:0] er, eok;
    logic [DW-1:0] ed [N];
    #1;
    g = -1;
    for (int i = 0; i < N; i++)
      dm[i] = vld[i] && op[i] == 2'd3 && !(m_rv[i] && m_ra[i] == ad[i]);
    for (int i = 0; i < N; i++)
      if (vld[i] && !dm[i] && g < 0) g = i;
    for (int i = 0; i < N; i++) begin
      er[i]  = dm[i] || i == g;
      eok[i] = (i == g) && op[i] == 2'd3;
      ed[i]  = ((i == g) && (op[i] == 2'd0 || op[i] == 2'd2)) ? m_mem[ad[i]] : '0;
    end
    check(tag, "ready", 64'(req_ready), 64'(er));
    last_rdy = er;
    for (int i = 0; i < N; i++) if (dm[i]) m_rv[i] = 0;
    if (g >= 0) begin
      if (op[g] == 2'd2) begin m_rv[g] = 1; m_ra[g] = ad[g]; end
      if (op[g] == 2'd1 || op[g] == 2'd3) begin
        m_mem[ad[g]] = wd[g];
        for (int j = 0; j < N; j++) if (j != g && m_ra[j] == ad[g]) m_rv[j] = 0;
        if (op[g] == 2'd3) m_rv[g] = 0;
      end
    end
    @(posedge clk); @(negedge clk);
    check(tag, "rsp_valid", 64'(rsp_valid), 64'(er));
    check(tag, "rsp_ok", 64'(rsp_ok), 64'(eok));
    for (int i = 0; i < N; i++)
      if (er[i]) check(tag, $sformatf("rsp_data[%0d]", i), 64'(rsp_data[DW*i +: DW]), 64'(ed[i]));
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clr();
    for (int k = 0; k < DEPTH; k++) m_mem[k] = '0;
    for (int i = 0; i < N; i++) begin m_rv[i] = 0; m_ra[i] = '0; end
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", 64'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", 64'(rsp_valid), 0);
    check("R1", "ready idle", 64'(req_ready), 0);
    put(2, 2'd3, 4'd1, 32'h55); cyc("R1"); clr();
    put(0, 2'd0, 4'd1, 0); cyc("R1"); clr();

    put(1, 2'd1, 4'd2, 32'hA5A5); cyc("R3"); clr();
    put(1, 2'd0, 4'd2, 0); cyc("R2"); clr();
    put(1, 2'd2, 4'd2, 0); cyc("R4"); clr();
    put(1, 2'd3, 4'd2, 32'h1111); cyc("R5"); clr();
    put(1, 2'd3, 4'd2, 32'h2222); cyc("R7"); clr();
    put(3, 2'd0, 4'd2, 0); cyc("R6"); clr();

    put(0, 2'd2, 4'd3, 0); cyc("R4"); clr();
    put(0, 2'd2, 4'd4, 0); cyc("R4"); clr();
    put(0, 2'd3, 4'd3, 32'h33); cyc("R4"); clr();
    put(0, 2'd0, 4'd3, 0); cyc("R6"); clr();

    put(0, 2'd2, 4'd6, 0); cyc("R8"); clr();
    put(2, 2'd2, 4'd6, 0); cyc("R8"); clr();
    put(3, 2'd1, 4'd6, 32'h0); cyc("R8"); clr();
    put(0, 2'd3, 4'd6, 32'h66); put(2, 2'd3, 4'd6, 32'h67); cyc("R8"); clr();
    put(3, 2'd2, 4'd6, 0); cyc("R8"); clr();
    put(3, 2'd1, 4'd6, 32'h9); cyc("R8"); clr();
    put(3, 2'd3, 4'd6, 32'h10); cyc("R8"); clr();

    put(1, 2'd2, 4'd7, 0); cyc("R6"); clr();
    put(2, 2'd2, 4'd7, 0); cyc("R6"); clr();
    put(2, 2'd3, 4'd8, 32'h88); cyc("R6"); clr();
    put(1, 2'd3, 4'd7, 32'h77); cyc("R6"); clr();

    put(0, 2'd2, 4'd5, 0); cyc("R11"); clr();
    put(1, 2'd2, 4'd5, 0); cyc("R11"); clr();
    put(0, 2'd3, 4'd5, 32'hC0); put(1, 2'd3, 4'd5, 32'hC1); cyc("R11");
    vld[0] = 0; cyc("R11"); clr();
    put(2, 2'd0, 4'd5, 0); cyc("R11"); clr();

    put(0, 2'd0, 4'd9, 0); put(1, 2'd1, 4'd9, 32'h5); put(3, 2'd3, 4'd9, 32'hE); cyc("R10");
    vld[0] = 0; cyc("R9"); clr();
    put(0, 2'd1, 4'd10, 1); put(1, 2'd1, 4'd10, 2); put(2, 2'd1, 4'd10, 3); cyc("R9");
    vld[0] = 0; cyc("R9"); vld[1] = 0; cyc("R9"); clr();

    last_rdy = '1;
    for (int t = 0; t < 600; t++) begin
      for (int i = 0; i < N; i++)
        if (!vld[i] || last_rdy[i]) begin
          if ($urandom_range(0, 3) == 0) vld[i] = 0;
          else put(i, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 3)), $urandom);
        end
      cyc("R5");
    end
    clr(); cyc("R2");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule